// File: doc/BRIEF.md
# Sixteen-Function Integer ALU

This block is a purely combinational 16-bit arithmetic and logic unit. It reads two unsigned operands, a left-hand operand A and a right-hand operand B, together with a 4-bit function code. From these it drives a result word and three flags: carry, zero and not-zero. A is always the left-hand operand, so subtraction gives A−B, division gives A/B, and the comparisons test A against B.

No start strobe or clock is involved. The output follows any change on the inputs, so a surrounding processor can keep the function code in a control register and read the result whenever it needs it. The block covers addition, subtraction, multiplication, integer division and remainder, unsigned magnitude compares, logical shifts, rotates and bitwise logic. Capturing the flags into a register is done outside this block.

Top module: `alu_core`

## Requirements
- R1: Code 4 gives (A+B) mod 2^16, code 3 gives (A−B) mod 2^16, and code 2 gives the low 16 bits of A×B.
- R2: Carry is set as follows. For code 4 it is the 17th bit of A+B. For code 3 it is the borrow, which is set exactly when A<B. For code 2 it is set when the upper 16 bits of the 32-bit product are non-zero.
- R3: When B≠0, code 1 gives the unsigned quotient floor(A/B) and code 0 gives the remainder A mod B. In both cases carry is cleared.
- R4: When B=0, code 0 and code 1 both give 16'hFFFF with carry set.
- R5: Code 6 gives 16'h0001 when A>B and 16'h0000 otherwise. Code 7 gives 16'h0001 when A<B and 16'h0000 otherwise. Both compares are unsigned, and equal operands give 0.
- R6: Code A shifts A right and code B shifts A left, in both cases by B[3:0] positions and filling with zeros. B[15:4] has no effect.
- R7: Code 8 rotates A right and code 9 rotates A left, in both cases by B[3:0] positions. B[15:4] has no effect.
- R8: Code C gives ~A, and B has no effect on it. Code D gives A^B, code E gives A|B, and code F gives A&B.
- R9: Code 5 is unused. It gives 16'h0000 with carry clear, whatever A and B are.
- R10: For codes 5 through F, carry is always clear.
- R11: The zero flag is set exactly when the result is 16'h0000, and the not-zero flag is always its complement.
- R12: The result and flags follow a change on A, B or the function code with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | Left-hand (primary) operand |
| opB | input | 16 | Right-hand operand; bits 3:0 give the shift and rotate distance |
| opSel | input | 4 | Function code |
| aluOut | output | 16 | Result word |
| carryFlag | output | 1 | Carry, borrow, product overflow or divide-by-zero indication |
| zeroFlag | output | 1 | Result equals zero |
| notZeroFlag | output | 1 | Result is non-zero |

## Verification
Some cases are hard to reach with uniform random operands. A divisor of zero occurs once in 65536 draws, and exactly equal operands for the compares are just as rare. The random generator therefore forces B to zero for about one vector in eight and copies A into B for another slice. Directed vectors cover the remaining boundaries: FFFF+1, 0−1, a product that just reaches 2^16, shift distances of 0 and 15, and B values whose upper bits are set but whose low nibble picks a small distance.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_MOD = 4'h0, OP_DIV = 4'h1, OP_MUL = 4'h2, OP_SUB = 4'h3,
    OP_ADD = 4'h4, OP_NONE = 4'h5, OP_GT = 4'h6, OP_LT = 4'h7,
    OP_ROR = 4'h8, OP_ROL = 4'h9, OP_SHR = 4'hA, OP_SHL = 4'hB,
    OP_NOT = 4'hC, OP_XOR = 4'hD, OP_OR = 4'hE, OP_AND = 4'hF
  } aluOp_e;

  // One strobe per functional unit; at most one is high.
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doMul;
    logic doDiv;
    logic doMod;
    logic doGt;
    logic doLt;
    logic doRor;
    logic doRol;
    logic doShr;
    logic doShl;
    logic doNot;
    logic doXor;
    logic doOr;
    logic doAnd;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output aluStrobe_t  strobes
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_MOD:  strobes.doMod = 1'b1;
      OP_DIV:  strobes.doDiv = 1'b1;
      OP_MUL:  strobes.doMul = 1'b1;
      OP_SUB:  strobes.doSub = 1'b1;
      OP_ADD:  strobes.doAdd = 1'b1;
      OP_GT:   strobes.doGt  = 1'b1;
      OP_LT:   strobes.doLt  = 1'b1;
      OP_ROR:  strobes.doRor = 1'b1;
      OP_ROL:  strobes.doRol = 1'b1;
      OP_SHR:  strobes.doShr = 1'b1;
      OP_SHL:  strobes.doShl = 1'b1;
      OP_NOT:  strobes.doNot = 1'b1;
      OP_XOR:  strobes.doXor = 1'b1;
      OP_OR:   strobes.doOr  = 1'b1;
      OP_AND:  strobes.doAnd = 1'b1;
      default: strobes = '0;
    endcase
  end

  always_comb begin
    AST_ONE_UNIT: assert ($onehot0(strobes)); // R1
    if (opSel == 4'h5) begin
      AST_IDLE_CODE: assert (strobes == '0); // R9
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobes,
  output logic [WIDTH-1:0] result,
  output logic             carry
);

  localparam int SHW = $clog2(WIDTH);
  localparam int DW  = 2 * WIDTH;

  logic [WIDTH:0]   sumExt;
  logic [WIDTH:0]   diffExt;
  logic [DW-1:0]    prod;
  logic             divZero;
  logic [WIDTH-1:0] quot;
  logic [WIDTH-1:0] rem;
  logic [SHW-1:0]   shAmt;
  logic [DW-1:0]    dblRight;
  logic [DW-1:0]    dblLeft;
  logic [WIDTH-1:0] rorVal;
  logic [WIDTH-1:0] rolVal;
  logic [WIDTH-1:0] cmpVal;

  assign sumExt  = {1'b0, opA} + {1'b0, opB};
  assign diffExt = {1'b0, opA} - {1'b0, opB};
  assign prod    = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};

  assign divZero = (opB == '0);
  assign quot    = divZero ? '1 : opA / opB;
  assign rem     = divZero ? '1 : opA % opB;

  assign shAmt    = opB[SHW-1:0];
  assign dblRight = {opA, opA} >> shAmt;
  assign dblLeft  = {opA, opA} << shAmt;
  assign rorVal   = dblRight[WIDTH-1:0];
  assign rolVal   = dblLeft[DW-1:WIDTH];

  assign cmpVal = {{(WIDTH-1){1'b0}},
                   (strobes.doGt & (opA > opB)) | (strobes.doLt & (opA < opB))};

  // AND-OR select across units driven by one-hot strobes.
  always_comb begin
    result = '0;
    result = result | ({WIDTH{strobes.doAdd}} & sumExt[WIDTH-1:0]);
    result = result | ({WIDTH{strobes.doSub}} & diffExt[WIDTH-1:0]);
    result = result | ({WIDTH{strobes.doMul}} & prod[WIDTH-1:0]);
    result = result | ({WIDTH{strobes.doDiv}} & quot);
    result = result | ({WIDTH{strobes.doMod}} & rem);
    result = result | cmpVal;
    result = result | ({WIDTH{strobes.doRor}} & rorVal);
    result = result | ({WIDTH{strobes.doRol}} & rolVal);
    result = result | ({WIDTH{strobes.doShr}} & (opA >> shAmt));
    result = result | ({WIDTH{strobes.doShl}} & (opA << shAmt));
    result = result | ({WIDTH{strobes.doNot}} & ~opA);
    result = result | ({WIDTH{strobes.doXor}} & (opA ^ opB));
    result = result | ({WIDTH{strobes.doOr}}  & (opA | opB));
    result = result | ({WIDTH{strobes.doAnd}} & (opA & opB));
  end

  always_comb begin
    carry = (strobes.doAdd & sumExt[WIDTH])
          | (strobes.doSub & diffExt[WIDTH])
          | (strobes.doMul & (|prod[DW-1:WIDTH]))
          | ((strobes.doDiv | strobes.doMod) & divZero);
  end

  always_comb begin
    if ((strobes.doDiv || strobes.doMod) && opB == '0) begin
      AST_DIV_BY_ZERO: assert (result == '1 && carry); // R4
    end
    if (strobes.doGt || strobes.doLt) begin
      AST_CMP_ONE_BIT: assert (result[WIDTH-1:1] == '0); // R5
    end
    if (carry) begin
      AST_CARRY_SOURCE: assert (strobes.doAdd || strobes.doSub || strobes.doMul
                                || strobes.doDiv || strobes.doMod); // R10
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] aluOut,
  output logic             carryFlag,
  output logic             zeroFlag,
  output logic             notZeroFlag
);

  aluStrobe_t strobes;

  alu_ctrl ctrl_i (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (aluOut),
    .carry   (carryFlag)
  );

  assign zeroFlag    = (aluOut == '0);
  assign notZeroFlag = ~zeroFlag;

  always_comb begin
    if (opSel == 4'h5) begin
      AST_IDLE_FLAGS: assert (zeroFlag && !carryFlag); // R9
    end
  end

endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  opSel = 4'h5;
  logic [15:0] aluOut;
  logic        carryFlag, zeroFlag, notZeroFlag;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  alu_core dut_i (
    .opA(opA), .opB(opB), .opSel(opSel),
    .aluOut(aluOut), .carryFlag(carryFlag),
    .zeroFlag(zeroFlag), .notZeroFlag(notZeroFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expResult(input logic [3:0] op,
                                             input logic [15:0] a,
                                             input logic [15:0] b);
    logic [31:0] wide;
    logic [15:0] v;
    int amt;
    amt = int'(b[3:0]);
    v = a;
    case (op)
      4'h0: return (b == 0) ? 16'hFFFF : a % b;
      4'h1: return (b == 0) ? 16'hFFFF : a / b;
      4'h2: begin wide = 32'(a) * 32'(b); return wide[15:0]; end
      4'h3: return 16'(32'(a) + 32'h10000 - 32'(b));
      4'h4: return 16'(32'(a) + 32'(b));
      4'h6: return (a > b) ? 16'd1 : 16'd0;
      4'h7: return (a < b) ? 16'd1 : 16'd0;
      4'h8: begin for (int i = 0; i < amt; i++) v = {v[0], v[15:1]}; return v; end
      4'h9: begin for (int i = 0; i < amt; i++) v = {v[14:0], v[15]}; return v; end
      4'hA: begin for (int i = 0; i < amt; i++) v = {1'b0, v[15:1]}; return v; end
      4'hB: begin for (int i = 0; i < amt; i++) v = {v[14:0], 1'b0}; return v; end
      4'hC: return ~a;
      4'hD: return a ^ b;
      4'hE: return a | b;
      4'hF: return a & b;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic expCarry(input logic [3:0] op,
                                    input logic [15:0] a,
                                    input logic [15:0] b);
    logic [31:0] wide;
    case (op)
      4'h0, 4'h1: return (b == 0);
      4'h2: begin wide = 32'(a) * 32'(b); return (wide >= 32'h10000); end
      4'h3: return (a < b);
      4'h4: return (32'(a) + 32'(b)) > 32'hFFFF;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] op, input logic [15:0] b);
    case (op)
      4'h0, 4'h1: return (b == 0) ? "R4" : "R3";
      4'h2, 4'h3, 4'h4: return "R1/R2";
      4'h5: return "R9";
      4'h6, 4'h7: return "R5";
      4'h8, 4'h9: return "R7";
      4'hA, 4'hB: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [16:0] got,
                          input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h (op=%h a=%h b=%h)",
               req, got, exp, opSel, opA, opB);
    end
  endtask

  // Drive on the falling edge, sample a quarter period later.
  task automatic applyVec(input logic [3:0] op, input logic [15:0] a,
                          input logic [15:0] b);
    logic [15:0] eR;
    logic        eC;
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    #(CLK_PERIOD/4);
    eR = expResult(op, a, b);
    eC = expCarry(op, a, b);
    checkVal(reqOf(op, b), {eC ^ carryFlag ^ eC, aluOut} & 17'h0FFFF | {carryFlag, 16'h0},
             {eC, eR});
    if (op >= 4'h5) checkVal("R10", {16'h0, carryFlag}, 17'h0);
    checkVal("R11", {15'h0, zeroFlag, notZeroFlag}, {15'h0, eR == 0, eR != 0});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    logic [3:0]  rOp;
    logic [15:0] rA, rB;
    int pick;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Initial state: code 5 with zero operands (R9).
    #(CLK_PERIOD/4);
    checkVal("R9", {carryFlag, aluOut}, 17'h0);

    // Directed corners.
    applyVec(4'h4, 16'hFFFF, 16'h0001);   // R2 add carry out, zero result
    applyVec(4'h4, 16'h1234, 16'h4321);   // R1
    applyVec(4'h3, 16'h0000, 16'h0001);   // R2 borrow
    applyVec(4'h3, 16'h0005, 16'h0005);   // R1 zero difference
    applyVec(4'h2, 16'h0100, 16'h0100);   // R2 product reaches 2^16
    applyVec(4'h2, 16'h00FF, 16'h00FF);   // R2 no overflow
    applyVec(4'h1, 16'h0007, 16'h0002);   // R3
    applyVec(4'h0, 16'h0007, 16'h0002);   // R3
    applyVec(4'h1, 16'h1234, 16'h0000);   // R4
    applyVec(4'h0, 16'h0000, 16'h0000);   // R4
    applyVec(4'h6, 16'h8000, 16'h8000);   // R5 equal
    applyVec(4'h7, 16'h8000, 16'h8000);   // R5 equal
    applyVec(4'h6, 16'h8000, 16'h7FFF);   // R5 unsigned
    applyVec(4'h7, 16'h0001, 16'hFFFF);   // R5
    applyVec(4'hA, 16'h8001, 16'h0000);   // R6 zero distance
    applyVec(4'hB, 16'h8001, 16'h000F);   // R6 max distance
    applyVec(4'hA, 16'hF0F0, 16'hFFF3);   // R6 upper B bits ignored
    applyVec(4'h8, 16'h0001, 16'h0001);   // R7
    applyVec(4'h9, 16'h8000, 16'h0001);   // R7
    applyVec(4'h9, 16'hA5C3, 16'h00F0);   // R7 upper B bits ignored
    applyVec(4'h8, 16'hA5C3, 16'h000F);   // R7
    applyVec(4'hC, 16'h0F0F, 16'h0000);   // R8
    applyVec(4'hC, 16'h0F0F, 16'hFFFF);   // R8 B has no effect
    applyVec(4'h5, 16'hFFFF, 16'hFFFF);   // R9

    // R12: operand change with no clock edge between.
    @(negedge clk);
    opSel = 4'h4; opA = 16'h0010; opB = 16'h0001;
    #1;
    checkVal("R12", {carryFlag, aluOut}, {1'b0, 16'h0011});
    opA = 16'hFFFF;
    #1;
    checkVal("R12", {carryFlag, aluOut}, {1'b1, 16'h0000});
    opSel = 4'hF;
    #1;
    checkVal("R12", {carryFlag, aluOut}, {1'b0, 16'h0001});

    // Constrained random.
    for (int n = 0; n < 3000; n++) begin
      rOp = 4'($urandom_range(0, 15));
      rA  = 16'($urandom);
      pick = $urandom_range(0, 15);
      if (pick < 2)       rB = 16'h0000;
      else if (pick < 4)  rB = rA;
      else if (pick < 7)  rB = 16'($urandom_range(0, 31));
      else                rB = 16'($urandom);
      applyVec(rOp, rA, rB);
    end

    finishRun();
  end

endmodule